// File: doc/BRIEF.md
# Paged Address Check and Exception Capture

This block sits between an instruction pipeline and memory. While the machine runs unprivileged, every logical address the core issues, whether an instruction fetch, an operand read or an operand write, is split into a virtual page number (address divided by 512) and a 9-bit offset. The page number is compared against the page-table length, and the page-table entry supplied for that page is inspected. A good access leaves as a physical address built from the entry's physical page and the unchanged offset.

The same block gathers the two other exception sources, illegal instruction from the decoder and divide or modulus by zero from the ALU. When any source fires, it raises a one-cycle exception strobe. In that same cycle it presents the handler entry address 1024 and requests the switch to privileged mode. On the next clock edge it loads a cause code, the faulting instruction pointer, and either the faulting page number or the offending address.

Only the first exception of an instruction is recorded. The core marks each new instruction with a start pulse, and that pulse re-arms capture. In privileged mode the block does nothing except pass addresses through untranslated.

Top module: `paged_xcpt_unit`

## Requirements
- R1: Unprivileged and with no exception raised, the physical address equals {pte_ppn_i, addr_i[8:0]}. The page number is addr_i[15:9] and acc_kind_i is coded 0 = fetch, 1 = read, 2 = write.
- R2: An access whose page number is not below ptlr_i (address at or above ptlr_i*512) loads cause 2 and copies the address into ema_o. epn_o is left unchanged.
- R3: A write (kind 2) to a valid, in-range page whose write-enable bit is 0 loads cause 2 and copies the address into ema_o. Reads and fetches of such a page are not affected.
- R4: An in-range access to a page whose valid bit is 0 loads cause 0 and copies the page number into epn_o, for any access kind. A write to a page that is both invalid and read-only counts as a page fault. ema_o is left unchanged.
- R5: ill_instr_i loads cause 1 and div_zero_i loads cause 3, whether or not an access is presented.
- R6: Every recorded exception copies ip_i into eip_o, including faults on operand accesses.
- R7: xcpt_o and to_priv_o are high in the cycle in which the exception source is presented. In that cycle new_ip_o reads 1024; otherwise it reads 0. The cause, IP, page and address registers change at the following clock edge.
- R8: If several sources fire in one cycle, the order is: a fault on a fetch access, then illegal instruction, then a fault on an operand access, then arithmetic.
- R9: After an exception, further sources of the same instruction raise no strobe and change no register until instr_start_i is high. A source presented together with instr_start_i is taken as belonging to the new instruction.
- R10: While priv_i is high, no strobe is raised, no register changes, and paddr_o equals addr_i.
- R11: After reset, ec_o, eip_o, epn_o and ema_o are 0 and no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_i | input | 1 | Machine is in privileged mode |
| instr_start_i | input | 1 | First cycle of a new instruction |
| acc_valid_i | input | 1 | An address is presented this cycle |
| acc_kind_i | input | 2 | 0 fetch, 1 read, 2 write |
| addr_i | input | 16 | Logical address |
| pte_valid_i | input | 1 | Page-table entry valid bit |
| pte_wen_i | input | 1 | Page-table entry write-enable bit |
| pte_ppn_i | input | 7 | Page-table entry physical page |
| ptlr_i | input | 8 | Number of pages in the address space |
| ip_i | input | 16 | Logical IP of the current instruction |
| ill_instr_i | input | 1 | Decoder flags an illegal instruction |
| div_zero_i | input | 1 | ALU flags division or modulus by zero |
| paddr_o | output | 16 | Physical address |
| xcpt_o | output | 1 | Exception strobe |
| new_ip_o | output | 16 | Handler IP while the strobe is high, else 0 |
| to_priv_o | output | 1 | Request to enter privileged mode |
| ec_o | output | 2 | Exception cause |
| eip_o | output | 16 | IP of the faulting instruction |
| epn_o | output | 7 | Faulting page number |
| ema_o | output | 16 | Offending address |

## Verification
The hardest case to reach is a collision of sources inside one instruction. Examples are a fetch fault arriving together with an illegal-instruction flag, or an operand fault that follows an earlier exception before the next start pulse, where the second event must leave every register untouched. The stimulus builds these cases deliberately: it holds instr_start_i low across several access cycles and raises decoder, ALU and page-table conditions together. It also places addresses exactly at the last valid byte, at the first byte past the table length, and at a table length of zero. A long randomized stretch then mixes privilege, start pulses and all sources, with a behavioural model compared on every clock.

// File: rtl/paged_xcpt_unit.sv
module paged_xcpt_unit #(
  parameter int AW         = 16,
  parameter int OFF_W      = 9,
  parameter int PPN_W      = 7,
  parameter int IP_W       = 16,
  parameter int HANDLER_IP = 1024
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  priv_i,
  input  logic                  instr_start_i,
  input  logic                  acc_valid_i,
  input  logic [1:0]            acc_kind_i,
  input  logic [AW-1:0]         addr_i,
  input  logic                  pte_valid_i,
  input  logic                  pte_wen_i,
  input  logic [PPN_W-1:0]      pte_ppn_i,
  input  logic [AW-OFF_W:0]     ptlr_i,
  input  logic [IP_W-1:0]       ip_i,
  input  logic                  ill_instr_i,
  input  logic                  div_zero_i,
  output logic [PPN_W+OFF_W-1:0] paddr_o,
  output logic                  xcpt_o,
  output logic [IP_W-1:0]       new_ip_o,
  output logic                  to_priv_o,
  output logic [1:0]            ec_o,
  output logic [IP_W-1:0]       eip_o,
  output logic [AW-OFF_W-1:0]   epn_o,
  output logic [AW-1:0]         ema_o
);
  localparam int VPN_W = AW - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam logic [1:0] EC_PF = 2'd0, EC_ILL = 2'd1, EC_IMA = 2'd2, EC_DZ = 2'd3;
  localparam logic [1:0] K_FETCH = 2'd0, K_WRITE = 2'd2;

  logic [VPN_W-1:0] vpn;
  logic in_rng, chk, pf, ima, armed, live, acc_f, fetch_f, op_f;
  logic done_q;
  logic [1:0] cause;

  assign vpn    = addr_i[AW-1:OFF_W];
  assign in_rng = {1'b0, vpn} < ptlr_i;
  assign chk    = acc_valid_i & ~priv_i;
  assign pf     = chk & in_rng & ~pte_valid_i;
  assign ima    = chk & (~in_rng | (pte_valid_i & (acc_kind_i == K_WRITE) & ~pte_wen_i));
  assign armed  = ~done_q | instr_start_i;
  assign live   = armed & ~priv_i;
  assign acc_f  = pf | ima;
  assign fetch_f = acc_f & (acc_kind_i == K_FETCH);
  assign op_f    = acc_f & (acc_kind_i != K_FETCH);

  always_comb begin
    if (fetch_f)          cause = pf ? EC_PF : EC_IMA;
    else if (ill_instr_i) cause = EC_ILL;
    else if (op_f)        cause = pf ? EC_PF : EC_IMA;
    else                  cause = EC_DZ;
  end

  assign xcpt_o    = live & (acc_f | ill_instr_i | div_zero_i);
  assign to_priv_o = xcpt_o;
  assign new_ip_o  = xcpt_o ? IP_W'(HANDLER_IP) : '0;
  assign paddr_o   = priv_i ? PA_W'(addr_i) : {pte_ppn_i, addr_i[OFF_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      ec_o   <= '0;
      eip_o  <= '0;
      epn_o  <= '0;
      ema_o  <= '0;
    end else begin
      if (instr_start_i) done_q <= xcpt_o;
      else if (xcpt_o)   done_q <= 1'b1;
      if (xcpt_o) begin
        ec_o  <= cause;
        eip_o <= ip_i;
        if (cause == EC_PF)  epn_o <= vpn;
        if (cause == EC_IMA) ema_o <= addr_i;
      end
    end
  end

  AST_OUT_OF_RANGE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !priv_i && !in_rng && armed) |-> xcpt_o); // R2
  AST_PF_PAGE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_o |=> (ec_o != EC_PF) || (epn_o == $past(vpn))); // R4
  AST_IMA_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_o |=> (ec_o != EC_IMA) || (ema_o == $past(addr_i))); // R2
  AST_EIP_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_o |=> eip_o == $past(ip_i)); // R6
  AST_ONE_PER_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_o |=> (!xcpt_o || instr_start_i)); // R9
  AST_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i |-> !xcpt_o); // R10
  AST_PRIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i |=> ($stable(ec_o) && $stable(eip_o) && $stable(epn_o) && $stable(ema_o))); // R10
  AST_HANDLER_IP: assert property (@(posedge clk) disable iff (!rst_n)
    xcpt_o |-> (new_ip_o == IP_W'(HANDLER_IP) && to_priv_o)); // R7
endmodule

// File: tb/paged_xcpt_unit_tb_top.sv
`timescale 1ns/1ps
module paged_xcpt_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic priv_i = 0, instr_start_i = 0, acc_valid_i = 0;
  logic [1:0] acc_kind_i = 0;
  logic [15:0] addr_i = 0;
  logic pte_valid_i = 0, pte_wen_i = 0;
  logic [6:0] pte_ppn_i = 0;
  logic [7:0] ptlr_i = 0;
  logic [15:0] ip_i = 0;
  logic ill_instr_i = 0, div_zero_i = 0;
  logic [15:0] paddr_o, new_ip_o, eip_o, ema_o;
  logic xcpt_o, to_priv_o;
  logic [1:0] ec_o;
  logic [6:0] epn_o;

  paged_xcpt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .instr_start_i(instr_start_i),
    .acc_valid_i(acc_valid_i), .acc_kind_i(acc_kind_i), .addr_i(addr_i),
    .pte_valid_i(pte_valid_i), .pte_wen_i(pte_wen_i), .pte_ppn_i(pte_ppn_i),
    .ptlr_i(ptlr_i), .ip_i(ip_i), .ill_instr_i(ill_instr_i), .div_zero_i(div_zero_i),
    .paddr_o(paddr_o), .xcpt_o(xcpt_o), .new_ip_o(new_ip_o), .to_priv_o(to_priv_o),
    .ec_o(ec_o), .eip_o(eip_o), .epn_o(epn_o), .ema_o(ema_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_ec = 0, m_eip = 0, m_epn = 0, m_ema = 0;
  bit m_done = 0;
  bit e_x;
  int e_cause;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(bit pr, bit st, bit av, int kind, int addr, bit pv, bit pw,
                       int ppn, int ptlr, int ip, bit ill, bit dz);
    priv_i = pr; instr_start_i = st; acc_valid_i = av; acc_kind_i = 2'(kind);
    addr_i = 16'(addr); pte_valid_i = pv; pte_wen_i = pw; pte_ppn_i = 7'(ppn);
    ptlr_i = 8'(ptlr); ip_i = 16'(ip); ill_instr_i = ill; div_zero_i = dz;
  endtask

  // expected strobe and cause from the requirements
  task automatic model_comb();
    int page;
    bit inr, pf, ima, live, fetchf, opf;
    page = int'(addr_i) / 512;
    inr  = page < int'(ptlr_i);
    pf   = acc_valid_i && !priv_i && inr && !pte_valid_i;
    ima  = acc_valid_i && !priv_i && (!inr || (pte_valid_i && acc_kind_i == 2 && !pte_wen_i));
    live = !priv_i && (!m_done || instr_start_i);
    fetchf = (pf || ima) && acc_kind_i == 0;
    opf    = (pf || ima) && acc_kind_i != 0;
    e_x = live && (pf || ima || ill_instr_i || div_zero_i);
    if (fetchf) e_cause = pf ? 0 : 2;
    else if (ill_instr_i) e_cause = 1;
    else if (opf) e_cause = pf ? 0 : 2;
    else e_cause = 3;
  endtask

  task automatic tick();
    #1;
    model_comb();
    chk("R7 strobe", int'(xcpt_o), int'(e_x));
    chk("R7 to_priv", int'(to_priv_o), int'(e_x));
    chk("R7 new_ip", int'(new_ip_o), e_x ? 1024 : 0);
    if (priv_i) chk("R10 paddr", int'(paddr_o), int'(addr_i));
    else if (!e_x && acc_valid_i)
      chk("R1 paddr", int'(paddr_o), int'(pte_ppn_i) * 512 + int'(addr_i) % 512);
    @(posedge clk);
    if (instr_start_i) m_done = e_x; else if (e_x) m_done = 1;
    if (e_x) begin
      m_ec = e_cause; m_eip = int'(ip_i);
      if (e_cause == 0) m_epn = int'(addr_i) / 512;
      if (e_cause == 2) m_ema = int'(addr_i);
    end
    #1;
    chk("R8 ec", int'(ec_o), m_ec);
    chk("R6 eip", int'(eip_o), m_eip);
    chk("R4 epn", int'(epn_o), m_epn);
    chk("R2 ema", int'(ema_o), m_ema);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    #5;
    // R11: reset state
    chk("R11 ec", int'(ec_o), 0);
    chk("R11 eip", int'(eip_o), 0);
    chk("R11 epn", int'(epn_o), 0);
    chk("R11 ema", int'(ema_o), 0);
    chk("R11 strobe", int'(xcpt_o), 0);
    rst_n = 1;
    @(posedge clk); #1;
    // R1: good fetch, read, write
    drive(0,1,1,0, 700, 1,0, 5, 8, 700, 0,0); tick();
    drive(0,0,1,1,1500, 1,0,17, 8, 700, 0,0); tick();
    drive(0,0,1,2,2000, 1,1,99, 8, 700, 0,0); tick();
    // R3: write to read-only valid page
    drive(0,0,1,2,2100, 1,0, 3, 8, 700, 0,0); tick();
    chk("R3 ec", int'(ec_o), 2); chk("R3 ema", int'(ema_o), 2100);
    // R9: further source same instruction ignored
    drive(0,0,0,0, 0, 1,1, 0, 8, 700, 0,1); tick();
    chk("R9 ec kept", int'(ec_o), 2);
    // R2: boundary, last valid byte then first illegal byte
    drive(0,1,1,1,4095, 1,1, 4, 8, 800, 0,0); tick();
    drive(0,0,1,1,4096, 1,1, 4, 8, 800, 0,0); tick();
    chk("R2 ec", int'(ec_o), 2); chk("R2 ema", int'(ema_o), 4096);
    // R4: operand page fault, EIP is instruction IP; invalid read-only write is PF
    drive(0,1,1,2,3000, 0,0, 0, 8, 900, 0,0); tick();
    chk("R4 ec", int'(ec_o), 0); chk("R4 epn", int'(epn_o), 5);
    chk("R6 eip", int'(eip_o), 900);
    // R4: fetch page fault
    drive(0,1,1,0, 600, 0,1, 0, 8, 600, 0,0); tick();
    chk("R4 fetch epn", int'(epn_o), 1);
    // R5: illegal instruction, arithmetic
    drive(0,1,0,0, 0, 1,1, 0, 8, 1234, 1,0); tick();
    chk("R5 ill", int'(ec_o), 1);
    drive(0,1,0,0, 0, 1,1, 0, 8, 1240, 0,1); tick();
    chk("R5 dz", int'(ec_o), 3);
    // R8: fetch fault beats illegal instruction; illegal beats operand fault
    drive(0,1,1,0,5000, 1,1, 0, 8, 5000, 1,1); tick();
    chk("R8 fetch first", int'(ec_o), 2);
    drive(0,1,1,1, 800, 0,1, 0, 8, 5100, 1,1); tick();
    chk("R8 ill first", int'(ec_o), 1);
    drive(0,1,1,1, 800, 0,1, 0, 8, 5200, 0,1); tick();
    chk("R8 operand before arith", int'(ec_o), 0);
    // R2: table length zero
    drive(0,1,1,0, 10, 1,1, 0, 0, 10, 0,0); tick();
    // R10: privileged, all sources ignored
    drive(1,1,1,2,60000, 0,0, 0, 0, 77, 1,1); tick();
    chk("R10 ec kept", int'(ec_o), 2);
    // randomized mix
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 6) == 0, ($urandom % 3) == 0, ($urandom % 4) != 0,
            $urandom % 3, $urandom % 65536, ($urandom % 5) != 0, $urandom % 2,
            $urandom % 128, $urandom % 140, $urandom % 65536,
            ($urandom % 9) == 0, ($urandom % 9) == 0);
      tick();
    end
    finish_run();
  end
endmodule